// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of a set of interrupt lines is presented to the processor. Each cycle it takes the captured request lines and the mask from the surrounding controller and forms the candidate set: requested and not masked. It ranks the candidates against a rotating priority offset and compares the best one with the best line already in service. A request is raised only when the candidate ranks strictly higher. The flag and the winning line number are registered, so they stay stable for a whole cycle before the processor acknowledges.

The block holds the in-service set and the rotation offset itself. On an acknowledge it either marks the presented line as in service or, in automatic end-of-interrupt mode, leaves the in-service set alone and can move the rotation so that the line just served drops to the lowest rank. It also latches the delivered vector: a programmable base with its low line-number bits replaced by the line. An acknowledge that arrives with no request present delivers the highest line number as a spurious code. On the primary instance of a cascaded pair, a nested-mode input makes the ranking skip the cascade line's in-service bit, so a second request arriving through the cascade can still get through.

Top module: `prio_resolver`

## Requirements
- R1: After reset, req_o is 0, isr_o is 0, rot_o is 0 (so line 0 has the highest rank) and vec_o is 0.
- R2: Only lines with pend_i set and mask_i clear can be presented; a masked line is never reported in line_o while req_o is 1.
- R3: The rank of line n is (n - rot_o) mod 8, with rank 0 the highest. The presented line is the candidate of lowest rank.
- R4: req_o is raised only when the best candidate's rank is strictly lower than the best in-service line's rank (an empty set ranks 8). A candidate that is itself in service does not request.
- R5: When the parameter IS_PRIMARY is 1 and nest_i is 1, in-service bit 2 (the cascade line) is left out of the in-service ranking. With IS_PRIMARY 0 or nest_i 0, that bit counts like any other.
- R6: An acknowledge while req_o is 1 and aeoi_i is 0 sets bit line_o of isr_o and leaves rot_o unchanged.
- R7: An acknowledge while req_o is 1 and aeoi_i is 1 leaves isr_o unchanged. If rot_aeoi_i is also 1, rot_o becomes (line_o + 1) mod 8; otherwise rot_o is unchanged.
- R8: On acknowledge, vec_o becomes base_i with bits 2:0 replaced by the line number; base_i bits 2:0 are ignored. vec_o holds until the next acknowledge.
- R9: An acknowledge while req_o is 0 sets vec_o bits 2:0 to 7 and changes neither isr_o nor rot_o.
- R10: req_o and line_o show the decision made from the inputs and state at the previous clock edge. In the cycle after an acknowledge, req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 8 | Captured request lines |
| mask_i | input | 8 | Mask, 1 blocks the line |
| nest_i | input | 1 | Nested mode: ignore the cascade line's in-service bit (primary only) |
| aeoi_i | input | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_i | input | 1 | Rotate on automatic end-of-interrupt |
| base_i | input | 8 | Vector base; bits 2:0 ignored |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| req_o | output | 1 | Interrupt request to the processor |
| line_o | output | 3 | Presented line number |
| vec_o | output | 8 | Vector latched at the last acknowledge |
| isr_o | output | 8 | In-service set |
| rot_o | output | 3 | Rotation offset |

## Verification
The hardest cases to reach are those with a non-zero rotation offset combined with a partly filled in-service set. The offset moves only when an automatically ended acknowledge with rotation enabled is taken. In-service bits build up only through normal acknowledges. The stimulus therefore flips the end-of-interrupt modes at random between acknowledges and pulses reset at random intervals, so that many offset and in-service combinations come up. Directed sequences cover the wrap of the scan past line 7, equal-rank blocking, and the cascade bit under nested mode on a primary and a secondary instance that run side by side.

// File: rtl/prio_pkg.sv
package prio_pkg;
   // Spurious code: the highest line number of a bank
   function automatic int unsigned spurious_line(input int unsigned lines);
      return lines - 1;
   endfunction
endpackage

// File: rtl/prio_rank.sv
// Relative rank of the lowest-ranked set bit, scanning upward from an offset.
// Empty set yields LINES.
module prio_rank #(
   parameter int unsigned LINES = 8,
   localparam int unsigned LW   = $clog2(LINES)
) (
   input  logic [LINES-1:0] set_i,
   input  logic [LW-1:0]    off_i,
   output logic [LW:0]      rank_o
);
   logic [LINES-1:0] rot_set;

   for (genvar p = 0; p < LINES; p++) begin : g_rot
      logic [LW+1:0] sum;
      logic [LW+1:0] idx;
      assign sum = (LW+2)'(p) + (LW+2)'(off_i);
      assign idx = (sum >= (LW+2)'(LINES)) ? sum - (LW+2)'(LINES) : sum;
      assign rot_set[p] = set_i[idx[LW-1:0]];
   end

   always_comb begin
      rank_o = (LW+1)'(LINES);
      for (int p = LINES - 1; p >= 0; p--) begin
         if (rot_set[p]) rank_o = (LW+1)'(p);
      end
   end
endmodule

// File: rtl/prio_ack_state.sv
// In-service set, rotation offset and vector latch, updated on acknowledge.
module prio_ack_state #(
   parameter int unsigned LINES = 8,
   parameter int unsigned VEC_W = 8,
   localparam int unsigned LW   = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_i,
   input  logic             pres_req_i,
   input  logic [LW-1:0]    pres_line_i,
   input  logic             aeoi_i,
   input  logic             rot_aeoi_i,
   input  logic [VEC_W-1:0] base_i,
   output logic [LINES-1:0] isr_o,
   output logic [LW-1:0]    off_o,
   output logic [VEC_W-1:0] vec_o
);
   localparam logic [LW-1:0] SPUR = LW'(prio_pkg::spurious_line(LINES));

   logic [LW:0]   next_off_w;
   logic [LW-1:0] next_off;

   assign next_off_w = (LW+1)'(pres_line_i) + (LW+1)'(1);
   assign next_off   = (next_off_w >= (LW+1)'(LINES)) ? '0 : next_off_w[LW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_o <= '0;
         off_o <= '0;
         vec_o <= '0;
      end else if (ack_i) begin
         if (pres_req_i) begin
            vec_o <= {base_i[VEC_W-1:LW], pres_line_i};
            if (aeoi_i) begin
               if (rot_aeoi_i) off_o <= next_off;
            end else begin
               isr_o[pres_line_i] <= 1'b1;
            end
         end else begin
            vec_o <= {base_i[VEC_W-1:LW], SPUR};
         end
      end
   end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
   parameter int unsigned LINES        = 8,
   parameter int unsigned VEC_W        = 8,
   parameter int unsigned CASCADE_LINE = 2,
   parameter bit          IS_PRIMARY   = 1'b1,
   localparam int unsigned LW          = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pend_i,
   input  logic [LINES-1:0] mask_i,
   input  logic             nest_i,
   input  logic             aeoi_i,
   input  logic             rot_aeoi_i,
   input  logic [VEC_W-1:0] base_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic [LW-1:0]    line_o,
   output logic [VEC_W-1:0] vec_o,
   output logic [LINES-1:0] isr_o,
   output logic [LW-1:0]    rot_o
);
   if (LINES < 2) begin : g_bad_lines
      $error("prio_resolver: LINES must be at least 2");
   end
   if (CASCADE_LINE >= LINES) begin : g_bad_casc
      $error("prio_resolver: CASCADE_LINE out of range");
   end
   if (VEC_W <= LW) begin : g_bad_vec
      $error("prio_resolver: VEC_W must exceed the line number width");
   end

   logic [LINES-1:0] cand;
   logic [LINES-1:0] svc_view;
   logic [LW:0]      cand_rank;
   logic [LW:0]      svc_rank;
   logic [LW+1:0]    line_sum;
   logic [LW-1:0]    win_line;
   logic             win;

   assign cand = pend_i & ~mask_i;

   if (IS_PRIMARY) begin : g_primary
      logic [LINES-1:0] casc_bit;
      assign casc_bit = LINES'(1) << CASCADE_LINE;
      assign svc_view = nest_i ? (isr_o & ~casc_bit) : isr_o;
   end else begin : g_secondary
      assign svc_view = isr_o;
   end

   prio_rank #(.LINES(LINES)) u_cand_rank (
      .set_i (cand),
      .off_i (rot_o),
      .rank_o(cand_rank)
   );

   prio_rank #(.LINES(LINES)) u_svc_rank (
      .set_i (svc_view),
      .off_i (rot_o),
      .rank_o(svc_rank)
   );

   assign win      = cand_rank < svc_rank;
   assign line_sum = (LW+2)'(cand_rank) + (LW+2)'(rot_o);
   assign win_line = (line_sum >= (LW+2)'(LINES)) ?
                     LW'(line_sum - (LW+2)'(LINES)) : LW'(line_sum);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o  <= 1'b0;
         line_o <= '0;
      end else begin
         req_o  <= win & ~ack_i;
         line_o <= win_line;
      end
   end

   prio_ack_state #(.LINES(LINES), .VEC_W(VEC_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_i      (ack_i),
      .pres_req_i (req_o),
      .pres_line_i(line_o),
      .aeoi_i     (aeoi_i),
      .rot_aeoi_i (rot_aeoi_i),
      .base_i     (base_i),
      .isr_o      (isr_o),
      .off_o      (rot_o),
      .vec_o      (vec_o)
   );
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
   parameter int unsigned LINES        = 8,
   parameter int unsigned VEC_W        = 8,
   parameter int unsigned CASCADE_LINE = 2,
   parameter bit          IS_PRIMARY   = 1'b1,
   localparam int unsigned LW          = $clog2(LINES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LINES-1:0] pend_i,
   input logic [LINES-1:0] mask_i,
   input logic             nest_i,
   input logic             aeoi_i,
   input logic             rot_aeoi_i,
   input logic             ack_i,
   input logic             req_o,
   input logic [LW-1:0]    line_o,
   input logic [VEC_W-1:0] vec_o,
   input logic [LINES-1:0] isr_o,
   input logic [LW-1:0]    rot_o
);
   logic [LINES-1:0] cand_d;
   logic [LINES-1:0] isr_d;
   logic             nest_d;

   always_ff @(posedge clk) begin
      cand_d <= pend_i & ~mask_i;
      isr_d  <= isr_o;
      nest_d <= nest_i;
   end

   assert_cand_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> cand_d[line_o]);

   assert_not_in_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !(IS_PRIMARY && nest_d && (int'(line_o) == CASCADE_LINE)))
      |-> !isr_d[line_o]);

   assert_ack_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && req_o && !aeoi_i) |=>
      (isr_o == ($past(isr_o) | (LINES'(1) << $past(line_o)))) && $stable(rot_o));

   assert_aeoi_keeps_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && aeoi_i) |=> $stable(isr_o));

   assert_aeoi_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && req_o && aeoi_i && rot_aeoi_i) |=>
      (rot_o == LW'(($past(int'(line_o)) + 1) % LINES)));

   assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !req_o) |=>
      ($stable(isr_o) && $stable(rot_o) && (vec_o[LW-1:0] == LW'(LINES - 1))));

   assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> ($stable(isr_o) && $stable(rot_o) && $stable(vec_o)));

   assert_drop_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> !req_o);
endmodule

bind prio_resolver prio_resolver_chk #(
   .LINES(LINES), .VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE), .IS_PRIMARY(IS_PRIMARY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i), .nest_i(nest_i),
   .aeoi_i(aeoi_i), .rot_aeoi_i(rot_aeoi_i), .ack_i(ack_i), .req_o(req_o),
   .line_o(line_o), .vec_o(vec_o), .isr_o(isr_o), .rot_o(rot_o)
);

// File: tb/tb_prio_resolver.sv
`timescale 1ns/1ps
module tb_prio_resolver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pend = '0, mask = '0, base = '0;
   logic       nest = 1'b0, aeoi = 1'b0, rot_aeoi = 1'b0, ack = 1'b0;

   logic       req_p, req_s;
   logic [2:0] line_p, line_s, rot_p, rot_s;
   logic [7:0] vec_p, vec_s, isr_p, isr_s;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   prio_resolver #(.IS_PRIMARY(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .nest_i(nest),
      .aeoi_i(aeoi), .rot_aeoi_i(rot_aeoi), .base_i(base), .ack_i(ack),
      .req_o(req_p), .line_o(line_p), .vec_o(vec_p), .isr_o(isr_p), .rot_o(rot_p));

   prio_resolver #(.IS_PRIMARY(1'b0)) dut_sec (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .nest_i(nest),
      .aeoi_i(aeoi), .rot_aeoi_i(rot_aeoi), .base_i(base), .ack_i(ack),
      .req_o(req_s), .line_o(line_s), .vec_o(vec_s), .isr_o(isr_s), .rot_o(rot_s));

   // reference model, index 0 primary, 1 secondary
   logic [7:0] m_isr [2];
   logic [2:0] m_off [2];
   logic       m_req [2];
   logic [2:0] m_line[2];
   logic [7:0] m_vec [2];

   function automatic int rank(input logic [7:0] s, input logic [2:0] off);
      for (int p = 0; p < 8; p++) if (s[(p + int'(off)) % 8]) return p;
      return 8;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      chk("R10 req_o primary", int'(req_p), int'(m_req[0]));
      chk("R10 req_o secondary", int'(req_s), int'(m_req[1]));
      if (m_req[0]) chk("R3 line_o primary", int'(line_p), int'(m_line[0]));
      if (m_req[1]) chk("R3 line_o secondary", int'(line_s), int'(m_line[1]));
      chk("R6 isr_o primary", int'(isr_p), int'(m_isr[0]));
      chk("R6 isr_o secondary", int'(isr_s), int'(m_isr[1]));
      chk("R7 rot_o primary", int'(rot_p), int'(m_off[0]));
      chk("R7 rot_o secondary", int'(rot_s), int'(m_off[1]));
      chk("R8 vec_o primary", int'(vec_p), int'(m_vec[0]));
      chk("R8 vec_o secondary", int'(vec_s), int'(m_vec[1]));
   endtask

   // inputs are set before calling; advances one edge and checks
   task automatic step();
      for (int k = 0; k < 2; k++) begin
         logic [7:0] view;
         int rc, rs;
         view = m_isr[k];
         if (k == 0 && nest) view[2] = 1'b0;
         rc = rank(pend & ~mask, m_off[k]);
         rs = rank(view, m_off[k]);
         if (ack) begin
            if (m_req[k]) begin
               m_vec[k] = {base[7:3], m_line[k]};
               if (aeoi) begin
                  if (rot_aeoi) m_off[k] = m_line[k] + 3'd1;
               end else begin
                  m_isr[k][m_line[k]] = 1'b1;
               end
            end else begin
               m_vec[k] = {base[7:3], 3'd7};
            end
         end
         m_req[k]  = (rc < rs) && !ack;
         m_line[k] = 3'((rc + int'(m_off[k]) - int'(m_off[k])) + int'(m_off[k]));
         if (rc < rs) m_line[k] = 3'((rc + int'(m_off[k] == m_off[k] ? m_off[k] : 3'd0)) % 8);
      end
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ack = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 2; k++) begin
         m_isr[k] = '0; m_off[k] = '0; m_req[k] = 1'b0; m_line[k] = '0; m_vec[k] = '0;
      end
      chk("R1 req_o", int'(req_p), 0);
      chk("R1 isr_o", int'(isr_p), 0);
      chk("R1 rot_o", int'(rot_p), 0);
      chk("R1 vec_o", int'(vec_p), 0);
   endtask

   task automatic drive(input logic [7:0] p, input logic [7:0] m, input logic a);
      pend = p; mask = m; ack = a;
      step();
      ack = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_1234));
      @(negedge clk);
      do_reset();

      // R2: masked line 4 skipped, line 5 wins
      base = 8'h40;
      drive(8'h30, 8'h10, 1'b0);
      chk("R2 masked line skipped", int'(line_p), 5);

      // R3 wrap: offset 0 picks line 0; rotate after AEOI ack to offset 1
      drive(8'h81, 8'h00, 1'b0);
      chk("R3 lowest rank at offset 0", int'(line_p), 0);
      aeoi = 1'b1; rot_aeoi = 1'b1;
      drive(8'h81, 8'h00, 1'b1);
      chk("R10 request dropped after ack", int'(req_p), 0);
      chk("R7 offset after rotate", int'(rot_p), 1);
      chk("R8 vector base plus line", int'(vec_p), 8'h40);
      chk("R7 isr untouched in AEOI", int'(isr_p), 0);
      drive(8'h81, 8'h00, 1'b0);
      chk("R3 scan wraps to line 7", int'(line_p), 7);
      aeoi = 1'b0; rot_aeoi = 1'b0;

      // R4: in-service compare
      do_reset();
      drive(8'h08, 8'h00, 1'b0);
      drive(8'h08, 8'h00, 1'b1);
      chk("R6 isr bit 3 set", int'(isr_p), 8'h08);
      drive(8'h08, 8'h00, 1'b0);
      chk("R4 equal rank blocked", int'(req_p), 0);
      drive(8'h10, 8'h00, 1'b0);
      chk("R4 lower rank blocked", int'(req_p), 0);
      drive(8'h02, 8'h00, 1'b0);
      chk("R4 higher rank passes", int'(req_p), 1);
      chk("R4 higher rank line", int'(line_p), 1);

      // R9: spurious acknowledge, base low bits ignored
      base = 8'h23;
      drive(8'h00, 8'h00, 1'b0);
      drive(8'h00, 8'h00, 1'b1);
      chk("R9 spurious vector", int'(vec_p), 8'h27);
      chk("R9 isr unchanged", int'(isr_p), 8'h08);

      // R5: cascade bit in service under nested mode
      do_reset();
      drive(8'h04, 8'h00, 1'b0);
      drive(8'h04, 8'h00, 1'b1);
      nest = 1'b1;
      drive(8'h04, 8'h00, 1'b0);
      chk("R5 primary nested passes cascade", int'(req_p), 1);
      chk("R5 secondary ignores nested", int'(req_s), 0);
      nest = 1'b0;
      drive(8'h04, 8'h00, 1'b0);
      chk("R5 primary nested off blocks", int'(req_p), 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 24 == 0) do_reset();
         pend     = 8'($urandom & $urandom);
         mask     = 8'($urandom & $urandom & $urandom);
         base     = 8'($urandom);
         nest     = 1'($urandom);
         aeoi     = ($urandom % 3) == 0;
         rot_aeoi = 1'($urandom);
         ack      = ($urandom % 3) == 0;
         step();
         ack = 1'b0;
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule